// File: doc/BRIEF.md
# Buffered Serial Transmitter with Collision Flag

This block is the sending half of an asynchronous serial port. Software places a byte in a one-entry holding buffer. In nine-bit mode it first places the top data bit in a separate ninth-bit register. When the shift engine is idle, the block wraps the buffered data in a low start bit and a high stop bit and shifts it out least significant bit first. Each bit lasts a programmable number of clock cycles. Because the buffer empties as soon as its contents move into the shift engine, the next byte can be written while the current frame is still on the line. Frames then follow one another with no idle gap.

Three status flags report the transmitter's state: holding buffer empty, shift engine empty, and write collision. A write to the buffer or to the ninth-bit register while the buffer is still occupied is dropped, the stored data is kept, and the collision flag is raised. Only a status read clears the collision flag. Each flag has its own mask bit onto a shared interrupt output. Clearing the enable input returns every flag to its default value and holds the line high.

Top module: `serial_tx_buffered`

## Requirements
- R1: While reset is asserted, and on the cycle after any edge at which `enable` is low, `flag_buf_empty`=1, `flag_shift_empty`=1, `flag_collision`=0 and `txd`=1. Writes sampled while disabled have no effect.
- R2: A data write sampled while enabled with the buffer empty stores `wr_data`. `flag_buf_empty` reads 0 on the following cycle.
- R3: A frame is one 0 start bit, then the data bits least significant first, then one 1 stop bit. Each bit holds `txd` for D cycles, where D is `divisor`, and a divisor of 0 counts as 1.
- R4: When the buffer holds data and the shift engine is idle, the next clock edge loads the frame. On the following cycle `txd`=0, `flag_shift_empty`=0 and `flag_buf_empty`=1.
- R5: If the buffer holds data when the last bit period of a frame ends, the next frame's start bit begins on the very next cycle. If the buffer is empty at that point, `flag_shift_empty` returns to 1 and `txd` idles high.
- R6: A write to `wr_data_en` or `wr_bit9_en` sampled while the buffer is occupied leaves the buffered data and ninth bit unchanged, and sets `flag_collision` on the next cycle.
- R7: `flag_collision` clears on the cycle after a `stat_rd` pulse. If a new collision is sampled in the same cycle as the read, the flag stays set.
- R8: Dropping `enable` in the middle of a frame aborts the frame and discards any buffered byte. After re-enabling, no stale frame is sent.
- R9: `irq` is 1 exactly when an enabled flag is set. Bit 0 of `irq_en` masks `flag_buf_empty`, bit 1 masks `flag_shift_empty`, and bit 2 masks `flag_collision`.
- R10: In nine-bit mode (`nine_bit_mode`=1, sampled at frame load) the frame is 11 bits long, with the ninth-bit register's value sent after data bit 7. In eight-bit mode the frame is 10 bits long. The ninth-bit register keeps its value across frames until it is rewritten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Module enable; low returns flags to defaults |
| divisor | input | 16 | Clock cycles per bit (0 treated as 1) |
| nine_bit_mode | input | 1 | 1 selects nine data bits per frame |
| wr_data_en | input | 1 | Write strobe for the holding buffer |
| wr_data | input | 8 | Byte written to the holding buffer |
| wr_bit9_en | input | 1 | Write strobe for the ninth-bit register |
| wr_bit9 | input | 1 | Value written to the ninth-bit register |
| stat_rd | input | 1 | Status read strobe; clears the collision flag |
| irq_en | input | 3 | Interrupt masks {collision, shift empty, buffer empty} |
| txd | output | 1 | Serial output, idles high |
| flag_buf_empty | output | 1 | Holding buffer empty |
| flag_shift_empty | output | 1 | Shift engine idle |
| flag_collision | output | 1 | A write was rejected |
| irq | output | 1 | OR of masked flags |

## Verification
The assertions assume that `divisor` and `nine_bit_mode` change only while the shift engine is idle, and that the strobes are single-cycle levels sampled at the rising edge. The bench changes the divisor and mode only after `flag_shift_empty` has returned to 1. It drives every strobe on the falling edge, so each strobe is stable at the sampling edge. Write bursts, collisions, status reads and mid-frame disables are placed relative to the observed flags. This keeps back-to-back loading, collisions at the load edge, and aborted frames all inside the assumed input envelope.

// File: rtl/tx_pkg.sv
package tx_pkg;
  localparam int FRAME_MAX = 11;

  // number of bits on the line for one frame
  function automatic int unsigned frame_len(input logic nine);
    return nine ? 32'd11 : 32'd10;
  endfunction

  // bit period in clocks, zero promoted to one
  function automatic logic [15:0] eff_period(input logic [15:0] div);
    return (div == 16'd0) ? 16'd1 : div;
  endfunction

  // frame image, bit 0 leaves first
  function automatic logic [FRAME_MAX-1:0] build_frame(input logic [7:0] data,
                                                       input logic bit9,
                                                       input logic nine);
    return nine ? {1'b1, bit9, data, 1'b0} : {2'b11, data, 1'b0};
  endfunction
endpackage

// File: rtl/tx_bit_timer.sv
module tx_bit_timer #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             run,
  input  logic             restart,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] last;

  assign last = (divisor == '0) ? '0 : divisor - 1'b1;
  assign tick = run && (cnt >= last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         cnt <= '0;
    else if (!enable || restart || !run) cnt <= '0;
    else if (cnt >= last)               cnt <= '0;
    else                                cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/tx_holding.sv
module tx_holding #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              wr_data_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_bit9_en,
  input  logic              wr_bit9,
  input  logic              stat_rd,
  input  logic              take,
  output logic              buf_full,
  output logic [DATA_W-1:0] buf_data,
  output logic              buf_bit9,
  output logic              collision,
  output logic              collide_evt
);
  assign collide_evt = enable && buf_full && (wr_data_en || wr_bit9_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_full  <= 1'b0;
      buf_data  <= '0;
      buf_bit9  <= 1'b0;
      collision <= 1'b0;
    end else if (!enable) begin
      buf_full  <= 1'b0;
      collision <= 1'b0;
    end else begin
      if (wr_data_en && !buf_full) begin
        buf_data <= wr_data;
        buf_full <= 1'b1;
      end else if (take) begin
        buf_full <= 1'b0;
      end
      if (wr_bit9_en && !buf_full) buf_bit9 <= wr_bit9;
      collision <= collide_evt || (collision && !stat_rd);
    end
  end
endmodule

// File: rtl/tx_shifter.sv
module tx_shifter
  import tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              tick,
  input  logic              buf_full,
  input  logic [DATA_W-1:0] buf_data,
  input  logic              buf_bit9,
  input  logic              nine_bit_mode,
  output logic              take,
  output logic              busy,
  output logic              frame_done,
  output logic              txd
);
  localparam int CNT_W = $clog2(FRAME_MAX + 1);

  logic [FRAME_MAX-1:0] shreg;
  logic [CNT_W-1:0]     left;

  assign frame_done = busy && tick && (left == CNT_W'(1));
  assign take       = enable && buf_full && (!busy || frame_done);
  assign txd        = busy ? shreg[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      shreg <= '1;
      left  <= '0;
    end else if (!enable) begin
      busy  <= 1'b0;
      shreg <= '1;
      left  <= '0;
    end else if (take) begin
      shreg <= build_frame(buf_data, buf_bit9, nine_bit_mode);
      left  <= CNT_W'(frame_len(nine_bit_mode));
      busy  <= 1'b1;
    end else if (busy && tick) begin
      shreg <= {1'b1, shreg[FRAME_MAX-1:1]};
      left  <= left - 1'b1;
      if (left == CNT_W'(1)) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/serial_tx_buffered.sv
module serial_tx_buffered #(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 16,
  parameter int N_FLAG = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [DIV_W-1:0]  divisor,
  input  logic              nine_bit_mode,
  input  logic              wr_data_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_bit9_en,
  input  logic              wr_bit9,
  input  logic              stat_rd,
  input  logic [N_FLAG-1:0] irq_en,
  output logic              txd,
  output logic              flag_buf_empty,
  output logic              flag_shift_empty,
  output logic              flag_collision,
  output logic              irq
);
  logic              take;
  logic              tick;
  logic              busy;
  logic              frame_done;
  logic              buf_full;
  logic [DATA_W-1:0] buf_data;
  logic              buf_bit9;
  logic              collide_evt;
  logic [N_FLAG-1:0] flags;

  tx_holding #(.DATA_W(DATA_W)) u_hold (
    .clk, .rst_n, .enable, .wr_data_en, .wr_data, .wr_bit9_en, .wr_bit9,
    .stat_rd, .take, .buf_full, .buf_data, .buf_bit9,
    .collision(flag_collision), .collide_evt
  );

  tx_bit_timer #(.DIV_W(DIV_W)) u_timer (
    .clk, .rst_n, .enable, .run(busy), .restart(take), .divisor, .tick
  );

  tx_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk, .rst_n, .enable, .tick, .buf_full, .buf_data, .buf_bit9,
    .nine_bit_mode, .take, .busy, .frame_done, .txd
  );

  assign flag_buf_empty   = !buf_full;
  assign flag_shift_empty = !busy;

  generate
    for (genvar i = 0; i < N_FLAG; i++) begin : g_mask
      if (i == 0)      assign flags[i] = flag_buf_empty;
      else if (i == 1) assign flags[i] = flag_shift_empty;
      else if (i == 2) assign flags[i] = flag_collision;
      else             assign flags[i] = 1'b0;
    end
  endgenerate

  assign irq = |(flags & irq_en);
endmodule

// File: rtl/serial_tx_buffered_checker.sv
module serial_tx_buffered_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       enable,
  input logic       wr_data_en,
  input logic       wr_bit9_en,
  input logic       stat_rd,
  input logic       txd,
  input logic       flag_buf_empty,
  input logic       flag_shift_empty,
  input logic       flag_collision,
  input logic       collide_evt,
  input logic       frame_done,
  input logic [2:0] irq_en,
  input logic       irq
);
  p_defaults_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (flag_buf_empty && flag_shift_empty && !flag_collision && txd));

  p_write_fills_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && wr_data_en && flag_buf_empty) |=> !flag_buf_empty);

  p_load_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !flag_buf_empty && flag_shift_empty)
      |=> (!txd && !flag_shift_empty && flag_buf_empty));

  p_idle_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    flag_shift_empty |-> txd);

  p_back_to_back_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && frame_done && !flag_buf_empty) |=> (!txd && !flag_shift_empty));

  p_collide_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && (wr_data_en || wr_bit9_en) && !flag_buf_empty) |=> flag_collision);

  p_read_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !collide_evt) |=> !flag_collision);

  p_irq_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en == 3'b000) |-> !irq);
endmodule

bind serial_tx_buffered serial_tx_buffered_checker u_chk (
  .clk, .rst_n, .enable, .wr_data_en, .wr_bit9_en, .stat_rd, .txd,
  .flag_buf_empty, .flag_shift_empty, .flag_collision,
  .collide_evt, .frame_done, .irq_en(irq_en[2:0]), .irq
);

// File: tb/serial_tx_buffered_test.sv
`timescale 1ns/1ps
module serial_tx_buffered_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic [15:0] divisor = 16'd3;
  logic        nine_bit_mode = 1'b0;
  logic        wr_data_en = 1'b0;
  logic [7:0]  wr_data = 8'h00;
  logic        wr_bit9_en = 1'b0;
  logic        wr_bit9 = 1'b0;
  logic        stat_rd = 1'b0;
  logic [2:0]  irq_en = 3'b000;
  logic txd, flag_buf_empty, flag_shift_empty, flag_collision, irq;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  serial_tx_buffered uut (
    .clk, .rst_n, .enable, .divisor, .nine_bit_mode, .wr_data_en, .wr_data,
    .wr_bit9_en, .wr_bit9, .stat_rd, .irq_en, .txd, .flag_buf_empty,
    .flag_shift_empty, .flag_collision, .irq
  );

  // behavioural reference: a queue of line bits and a cycle counter
  bit   m_q[$];
  int   m_cnt = 0;
  bit   m_full = 0, m_coll = 0, m_b9 = 0;
  logic [7:0] m_data = 8'h00;

  always @(posedge clk) begin
    int  per;
    bit  full_old;
    per = (divisor == 0) ? 1 : int'(divisor);
    if (!rst_n) begin
      m_q.delete(); m_cnt = 0; m_full = 0; m_coll = 0; m_b9 = 0; m_data = 0;
    end else if (!enable) begin
      m_q.delete(); m_cnt = 0; m_full = 0; m_coll = 0;
    end else begin
      full_old = m_full;
      if (m_q.size() > 0) begin
        if (m_cnt >= per - 1) begin m_cnt = 0; void'(m_q.pop_front()); end
        else m_cnt++;
      end
      if (full_old && m_q.size() == 0) begin
        m_q.push_back(1'b0);
        for (int i = 0; i < 8; i++) m_q.push_back(m_data[i]);
        if (nine_bit_mode) m_q.push_back(m_b9);
        m_q.push_back(1'b1);
        m_cnt = 0;
        m_full = 0;
      end
      m_coll = (full_old && (wr_data_en || wr_bit9_en)) || (m_coll && !stat_rd);
      if (!full_old && wr_data_en) begin m_data = wr_data; m_full = 1; end
      if (!full_old && wr_bit9_en) m_b9 = wr_bit9;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at %0t: actual=%0d expected=%0d", tag, $time, act, exp);
    end
  endtask

  // compare every cycle away from the rising edge
  always @(negedge clk) begin
    bit e_txd, e_se;
    bit [2:0] fl;
    if (!done) begin
      e_txd = (m_q.size() > 0) ? m_q[0] : 1'b1;
      e_se  = (m_q.size() == 0);
      fl    = {m_coll, e_se, !m_full};
      check(txd == e_txd, "R3/R5 txd line", txd, e_txd);
      check(flag_buf_empty == !m_full, "R2/R4 buffer-empty", flag_buf_empty, !m_full);
      check(flag_shift_empty == e_se, "R5 shift-empty", flag_shift_empty, e_se);
      check(flag_collision == m_coll, "R6/R7 collision", flag_collision, m_coll);
      check(irq == |(fl & irq_en), "R9 irq", irq, |(fl & irq_en));
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put_byte(input logic [7:0] d);
    wr_data = d; wr_data_en = 1'b1; cyc(1); wr_data_en = 1'b0;
  endtask

  task automatic put_bit9(input logic b);
    wr_bit9 = b; wr_bit9_en = 1'b1; cyc(1); wr_bit9_en = 1'b0;
  endtask

  task automatic wait_buf_empty();
    for (int i = 0; i < 2000 && !flag_buf_empty; i++) cyc(1);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 5000 && !flag_shift_empty; i++) cyc(1);
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    #200000;
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    cyc(3);
    // R1: reset state
    check(flag_buf_empty && flag_shift_empty && !flag_collision && txd,
          "R1 reset defaults", {flag_buf_empty, flag_shift_empty, flag_collision, txd}, 4'b1101);
    rst_n = 1'b1;
    cyc(2);
    put_byte(8'h3C);   // R1: write while disabled ignored
    cyc(2);
    check(flag_buf_empty && flag_shift_empty, "R1 disabled write ignored",
          {flag_buf_empty, flag_shift_empty}, 2'b11);

    enable = 1'b1; irq_en = 3'b111; divisor = 16'd3;
    cyc(2);
    // R2/R4: single frame
    put_byte(8'hA5);
    check(!flag_buf_empty, "R2 buffer filled", flag_buf_empty, 0);
    cyc(1);
    check(!txd && flag_buf_empty, "R4 start bit loaded", {txd, flag_buf_empty}, 2'b01);
    // R5: back-to-back, next byte while shifting
    put_byte(8'h5A);
    // R6: collision on occupied buffer, data kept
    put_byte(8'hFF);
    check(flag_collision, "R6 collision set", flag_collision, 1);
    put_bit9(1'b1);
    // R7: status read clears
    stat_rd = 1'b1; cyc(1); stat_rd = 1'b0;
    check(!flag_collision, "R7 read clears", flag_collision, 0);
    wait_idle();
    cyc(3);

    // R7: read and collision in the same cycle keeps the flag
    irq_en = 3'b000;
    put_byte(8'h81);
    wr_data = 8'h18; wr_data_en = 1'b1; stat_rd = 1'b1; cyc(1);
    wr_data_en = 1'b0; stat_rd = 1'b0;
    check(flag_collision, "R7 set wins over read", flag_collision, 1);
    check(!irq, "R9 masked irq", irq, 0);
    irq_en = 3'b100;
    cyc(1);
    check(irq, "R9 collision irq", irq, 1);
    stat_rd = 1'b1; cyc(1); stat_rd = 1'b0;
    wait_idle();

    // R10: nine-bit mode with divisor 1 and 0
    nine_bit_mode = 1'b1; irq_en = 3'b011;
    for (int d = 0; d < 3; d++) begin
      divisor = 16'(d);
      put_bit9(d[0]);
      put_byte(8'h96 + 8'(d));
      wait_buf_empty();
      put_byte(8'h0F);     // ninth bit kept from previous write
      wait_idle();
      cyc(2);
    end

    // R8: disable mid frame discards everything
    nine_bit_mode = 1'b0; divisor = 16'd4;
    put_byte(8'hC3);
    wait_buf_empty();
    put_byte(8'h24);
    cyc(10);
    enable = 1'b0; cyc(1);
    check(txd && flag_shift_empty && flag_buf_empty && !flag_collision,
          "R8 abort to defaults", {txd, flag_shift_empty, flag_buf_empty, flag_collision}, 4'b1110);
    enable = 1'b1; cyc(30);
    check(flag_shift_empty && txd, "R8 no stale frame", {flag_shift_empty, txd}, 2'b11);

    // R5/R3: burst of four bytes, no gap
    divisor = 16'd2;
    for (int k = 0; k < 4; k++) begin
      wait_buf_empty();
      put_byte(8'h11 * 8'(k + 1));
    end
    wait_idle();
    cyc(5);
    finish_run();
  end
endmodule